// File: doc/BRIEF.md
# Ordered Three-Input Rise Detector

The block watches three single-bit inputs, `in_a`, `in_b` and `in_c`, and raises `match_o` only when all three have gone high one at a time in the fixed order a, then b, then c, beginning from a condition in which all three were low. Each input is first passed through a two-flop synchronizer. A small synchronous state machine then follows the synchronized vector on every clock edge. Internally the vector is packed with `in_a` in bit 0, `in_b` in bit 1 and `in_c` in bit 2. The only accepted progression is therefore 000, 001, 011, 111 (written c,b,a).

The machine has three states. `ST_ARMED` combines the idle wait with the partial progress after a and after a,b. It stays put while the vector does not change, and it accepts only the next single rising input. `ST_MATCH` holds the output high while all inputs stay high. `ST_DRAIN` is the out-of-sequence state, and it waits for all inputs to be low.

The transitions are:
- ARMED→ARMED on no change, or on an in-order rise that is not yet complete.
- ARMED→MATCH on the rise of c that completes the order.
- ARMED→DRAIN on any other change.
- MATCH→ARMED when all inputs fall together.
- MATCH→DRAIN when some, but not all, inputs fall.
- DRAIN→ARMED once all inputs are low.

`match_o` is a register loaded from the next state, so it cannot glitch.

Top module: `ord_rise_detector`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after it, `match_o` is 0 and the machine is in `ST_ARMED` with a recorded previous vector of 000. This holds even if reset arrives while `match_o` is high.
- R2: Each input passes two synchronizer flops and then the output register. When the final in-order rise of `in_c` is applied, `match_o` is still 0 after two rising clock edges and is 1 after the third.
- R3: Starting from all low, raising a, then b, then c, one per sampled cycle or further apart, sets `match_o` to 1. It stays 1 for as long as all three inputs remain high.
- R4: A rise in any other order (for example b before a) leads to `ST_DRAIN`. `match_o` then stays 0 even after all three inputs become high.
- R5: From `ST_DRAIN`, `match_o` stays 0 until the synchronized vector has been 000. After that, a fresh in-order progression sets `match_o` again.
- R6: If two or more synchronized inputs change in the same cycle, this is treated as out of sequence, including 000→111.
- R7: If some but not all inputs fall while `match_o` is 1, `match_o` drops with the usual latency. It stays 0 when the fallen input rises again, until the vector has been 000.
- R8: If all three inputs fall in the same cycle while `match_o` is 1, the machine goes directly to `ST_ARMED`, and a new in-order progression matches again.
- R9: A falling input while partial progress is held in `ST_ARMED` (for example 011→001) is out of sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_a | input | 1 | First input of the order, asynchronous |
| in_b | input | 1 | Second input of the order, asynchronous |
| in_c | input | 1 | Third input of the order, asynchronous |
| match_o | output | 1 | High while the ordered rise is complete and all inputs are held high |

## Verification
Two functions can act in the same cycle: following the order and the out-of-sequence detection. They collide when two inputs are changed at the same falling clock edge, so that both reach the synchronized vector together. This happens with a and b rising at once, with all three rising from 000, and with a partial fall while matched. In each case the bench judges the result against a behavioural model that tracks a previous-vector integer. Its rule is that one new bit is accepted only when it is the next in order, and any multi-bit change sends the model to the drain state. The model is compared with `match_o` on every clock. Latency is checked separately at the exact edges counted from the pins.

// File: rtl/ord_rise_pkg.sv
package ord_rise_pkg;
    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_MATCH = 2'd1,
        ST_DRAIN = 2'd2
    } ord_state_e;
endpackage

// File: rtl/ord_rise_sync.sv
module ord_rise_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/ord_rise_fsm.sv
module ord_rise_fsm
    import ord_rise_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] vec_i,
    output logic             match_o
);
    localparam logic [WIDTH-1:0] ALL_HIGH = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ALL_LOW  = '0;

    ord_state_e       state_q, state_d;
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] delta;
    logic [WIDTH-1:0] next_step;
    logic             step_ok;
    logic             multi_change;
    logic             match_q;

    assign delta        = vec_i ^ prev_q;
    assign next_step    = {prev_q[WIDTH-2:0], 1'b1};
    assign step_ok      = (vec_i == next_step);
    assign multi_change = (delta & (delta - 1'b1)) != '0;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: begin
                if (delta == '0)
                    state_d = ST_ARMED;
                else if (step_ok && !multi_change)
                    state_d = (vec_i == ALL_HIGH) ? ST_MATCH : ST_ARMED;
                else
                    state_d = ST_DRAIN;
            end
            ST_MATCH: begin
                if (vec_i == ALL_HIGH)
                    state_d = ST_MATCH;
                else if (vec_i == ALL_LOW)
                    state_d = ST_ARMED;
                else
                    state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                state_d = (vec_i == ALL_LOW) ? ST_ARMED : ST_DRAIN;
            end
            default: state_d = ST_ARMED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_ARMED;
        else     state_q <= state_d;
    end

    // output and history registers
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            match_q <= 1'b0;
        end else begin
            prev_q  <= vec_i;
            match_q <= (state_d == ST_MATCH);
        end
    end

    assign match_o = match_q;

    // R3: output high implies all inputs were high at the update
    assert_match_all_high_R3: assert property (@(posedge clk) disable iff (rst)
        match_q |-> ($past(vec_i) == ALL_HIGH));

    // R5: leaving the drain state needs an all-low vector
    assert_drain_exit_low_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == ST_DRAIN && state_q != ST_DRAIN) |-> ($past(vec_i) == ALL_LOW));

    // R6: simultaneous changes while armed go out of sequence
    assert_multi_change_oos_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARMED && $countones(vec_i ^ prev_q) > 1) |=> (state_q == ST_DRAIN && !match_q));

    // R7: partial fall while matched drops the output
    assert_partial_fall_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MATCH && vec_i != ALL_HIGH && vec_i != ALL_LOW) |=> !match_q);

    // R1: the cycle after reset is idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        $rose(rst) |=> (state_q == ST_ARMED && !match_q && prev_q == ALL_LOW));
endmodule

// File: rtl/ord_rise_detector.sv
module ord_rise_detector #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic in_a,
    input  logic in_b,
    input  logic in_c,
    output logic match_o
);
    localparam int NUM_IN = 3;

    logic [NUM_IN-1:0] raw_vec;
    logic [NUM_IN-1:0] sync_vec;

    assign raw_vec = {in_c, in_b, in_a};

    ord_rise_sync #(
        .WIDTH  (NUM_IN),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw_vec),
        .sync_o  (sync_vec)
    );

    ord_rise_fsm #(
        .WIDTH (NUM_IN)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .vec_i   (sync_vec),
        .match_o (match_o)
    );
endmodule

// File: tb/ord_rise_detector_tb.sv
`timescale 1ns/1ps
module ord_rise_detector_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_a = 1'b0, in_b = 1'b0, in_c = 1'b0;
    logic match_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ord_rise_detector u_dut (
        .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .in_c(in_c), .match_o(match_o)
    );

    // behavioural reference: 0 armed, 1 matched, 2 draining
    int m_s1 = 0, m_s2 = 0, m_prev = 0, m_mode = 0;
    bit m_u = 0;
    string m_tag = "R1";

    function automatic int bits_set(int x);
        int n = 0;
        for (int i = 0; i < 3; i++) if (x[i]) n++;
        return n;
    endfunction

    always @(posedge clk) begin
        int v, want;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_mode = 0; m_u = 0; m_tag = "R1";
        end else begin
            v = m_s2;
            if (m_mode == 0) begin
                want = (m_prev == 0) ? 1 : (m_prev == 1) ? 3 : 7;
                if (v == m_prev) begin
                    // hold
                end else if (bits_set(v ^ m_prev) > 1) begin
                    m_mode = 2; m_tag = "R6";
                end else if (v < m_prev) begin
                    m_mode = 2; m_tag = "R9";
                end else if (v == want) begin
                    m_mode = (v == 7) ? 1 : 0; m_tag = "R3";
                end else begin
                    m_mode = 2; m_tag = "R4";
                end
            end else if (m_mode == 1) begin
                if (v == 0) begin m_mode = 0; m_tag = "R8"; end
                else if (v != 7) begin m_mode = 2; m_tag = "R7"; end
            end else begin
                if (v == 0) begin m_mode = 0; m_tag = "R5"; end
            end
            m_prev = v;
            m_s2 = m_s1;
            m_s1 = {29'd0, in_c, in_b, in_a};
            m_u = (m_mode == 1);
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        checks++;
        if (match_o !== m_u) begin
            errors++;
            $display("FAIL %s model compare: actual=%0b expected=%0b at %0t", m_tag, match_o, m_u, $time);
        end
    end

    task automatic expect_u(input bit e, input string req);
        checks++;
        if (match_o !== e) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, match_o, e, $time);
        end
    endtask

    task automatic drive(input logic [2:0] cba, input int cyc);
        {in_c, in_b, in_a} = cba;
        repeat (cyc) @(negedge clk);
    endtask

    task automatic good_seq();
        drive(3'b001, 4);
        drive(3'b011, 4);
        drive(3'b111, 4);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_u(1'b0, "R1");
        rst = 1'b0;
        drive(3'b000, 2);
        expect_u(1'b0, "R1");

        // R2 latency and R3 match
        drive(3'b001, 4);
        drive(3'b011, 4);
        {in_c, in_b, in_a} = 3'b111;
        @(posedge clk); @(posedge clk); @(negedge clk);
        expect_u(1'b0, "R2");
        @(posedge clk); @(negedge clk);
        expect_u(1'b1, "R2");
        repeat (5) @(negedge clk);
        expect_u(1'b1, "R3");

        // R8 all fall together, re-arm
        drive(3'b000, 4);
        expect_u(1'b0, "R8");
        good_seq();
        expect_u(1'b1, "R8");

        // R7 partial fall, recovery blocked until zero
        drive(3'b011, 4);
        expect_u(1'b0, "R7");
        drive(3'b111, 4);
        expect_u(1'b0, "R7");
        drive(3'b000, 4);
        good_seq();
        expect_u(1'b1, "R5");

        // R4 wrong order
        drive(3'b000, 4);
        drive(3'b010, 4);
        drive(3'b011, 4);
        drive(3'b111, 4);
        expect_u(1'b0, "R4");
        drive(3'b011, 4);
        expect_u(1'b0, "R5");
        drive(3'b000, 4);
        good_seq();
        expect_u(1'b1, "R5");

        // R6 simultaneous changes
        drive(3'b000, 4);
        drive(3'b011, 4);
        drive(3'b111, 4);
        expect_u(1'b0, "R6");
        drive(3'b000, 4);
        drive(3'b111, 4);
        expect_u(1'b0, "R6");

        // R9 fall while partially armed
        drive(3'b000, 4);
        drive(3'b001, 4);
        drive(3'b011, 4);
        drive(3'b001, 4);
        drive(3'b011, 4);
        drive(3'b111, 4);
        expect_u(1'b0, "R9");
        drive(3'b000, 4);
        good_seq();
        expect_u(1'b1, "R3");

        // R1 reset while matched
        rst = 1'b1;
        @(negedge clk);
        expect_u(1'b0, "R1");
        rst = 1'b0;
        drive(3'b111, 4);
        expect_u(1'b0, "R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule